// File: doc/BRIEF.md
# Internal Data Memory Address Decoder

This block sits between an 8-bit core's operand logic and its internal data storage. Each request carries a byte address, an addressing mode, a register number and the active register-bank field. The block resolves the request onto one of three physically separate targets: a 128-byte lower RAM, a 128-byte upper RAM, and an external special-function-register (SFR) port. It then steers the read or the write to that target alone. The addresses 80h to FFh lead to two different places. A direct access in that range reaches the SFR port, and an indirect access reaches the upper RAM. This gives 384 bytes behind a one-byte address.

Register operands R0 to R7 are relocated into the lowest 32 bytes by the two-bit bank field. Bit addresses are turned into the byte that holds the bit, together with the bit position. A build parameter removes the upper RAM. In that build, indirect accesses above 7Fh read as zero and their writes are dropped. The block owns both RAM arrays. It does not hold SFR contents: it presents an SFR address, an enable and write data, and it samples the SFR read data on the same edge.

Top module: `idm_decoder`

## Requirements
- R1: After a synchronous active-high reset, `rd_valid` is 0 and `sfr_en` and `sfr_we` are 0 while no request is presented.
- R2: Mode encoding is 0=direct, 1=indirect, 2=register, 3=bit. A direct or indirect access to addresses 00h-7Fh selects the lower RAM, and the result reports target code 0 and offset equal to the address.
- R3: A direct access at 80h or above selects the SFR port. `sfr_en` is high in the request cycle with `sfr_addr` equal to the address. The result reports target code 2, offset address-80h, and the SFR read data sampled at the request edge.
- R4: With the upper RAM present, an indirect access at 80h or above selects the upper RAM (target code 1, offset address-80h). This storage is separate from the SFR space.
- R5: A register-mode access to Rn with bank b selects lower RAM byte b*8+n, and the address input is ignored.
- R6: A bit-mode access with bit address a below 80h selects lower RAM byte 20h+(a>>3) and reports bit position a[2:0]. For a at 80h or above, it selects SFR byte a with its low three bits cleared.
- R7: A read request produces `rd_valid` and its data exactly one cycle later. Write requests and idle cycles produce no `rd_valid`.
- R8: A write changes only the selected target. `sfr_we` is asserted only for SFR-targeted writes, and RAM writes never reach the SFR port or the other RAM.
- R9: Without the upper RAM, indirect accesses at 80h or above report target code 3 and read as 0, and writes to them are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | Addressing mode (R2 encoding) |
| req_addr | input | 8 | Byte or bit address |
| req_reg | input | 3 | Register number for register mode |
| bank_sel | input | 2 | Active register bank |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |
| rd_target | output | 2 | Target code of the result |
| rd_offset | output | 7 | Physical offset within the target |
| rd_bitpos | output | 3 | Bit position for bit-mode reads |
| sfr_en | output | 1 | SFR access this cycle |
| sfr_we | output | 1 | SFR write strobe |
| sfr_addr | output | 8 | SFR byte address |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data for `sfr_addr` |

## Verification
The SFR strobes, address and write data are combinational, so they are checked shortly after the inputs change and before the next rising edge. Read results come out one edge after the request. The bench drives each request on a falling edge, waits for the rising edge that captures it, and checks `rd_valid`, data, target, offset and bit position on the falling edge that follows. A write request is checked the same way, and `rd_valid` must stay low at that sample point. A bench model of both RAMs, updated on every write, gives the expected data. A second instance without the upper RAM receives the same stimulus.

// File: rtl/idm_pkg.sv
package idm_pkg;
  typedef enum logic [1:0] {
    MODE_DIR = 2'd0,
    MODE_IND = 2'd1,
    MODE_REG = 2'd2,
    MODE_BIT = 2'd3
  } idm_mode_e;

  typedef enum logic [1:0] {
    TGT_LOW  = 2'd0,
    TGT_UP   = 2'd1,
    TGT_SFR  = 2'd2,
    TGT_NONE = 2'd3
  } idm_tgt_e;
endpackage

// File: rtl/idm_addr_map.sv
module idm_addr_map
  import idm_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int REG_W     = 3,
  parameter int BANK_W    = 2,
  parameter int BIT_BASE  = 32,
  parameter bit HAS_UPPER = 1'b1,
  localparam int OFF_W    = ADDR_W - 1
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  rsel,
  input  logic [BANK_W-1:0] bank,
  output idm_tgt_e          tgt,
  output logic [OFF_W-1:0]  off,
  output logic [2:0]        bitpos
);
  localparam int PAD_W = OFF_W - REG_W - BANK_W;

  logic             hi;
  logic [OFF_W-1:0] low_part;
  logic [OFF_W-1:0] bit_byte;

  assign hi       = addr[ADDR_W-1];
  assign low_part = addr[OFF_W-1:0];
  assign bit_byte = OFF_W'(BIT_BASE) + OFF_W'(addr[OFF_W-1:3]);

  always_comb begin
    tgt    = TGT_LOW;
    off    = low_part;
    bitpos = 3'd0;
    unique case (idm_mode_e'(mode))
      MODE_DIR: tgt = hi ? TGT_SFR : TGT_LOW;
      MODE_IND: tgt = hi ? (HAS_UPPER ? TGT_UP : TGT_NONE) : TGT_LOW;
      MODE_REG: begin
        tgt = TGT_LOW;
        off = {{PAD_W{1'b0}}, bank, rsel};
      end
      MODE_BIT: begin
        bitpos = addr[2:0];
        if (hi) begin
          tgt = TGT_SFR;
          off = {low_part[OFF_W-1:3], 3'b000};
        end else begin
          tgt = TGT_LOW;
          off = bit_byte;
        end
      end
      default: tgt = TGT_LOW;
    endcase
  end
endmodule

// File: rtl/idm_spram.sv
module idm_spram #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/idm_decoder.sv
module idm_decoder
  import idm_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int REG_W     = 3,
  parameter int BANK_W    = 2,
  parameter int BIT_BASE  = 32,
  parameter bit HAS_UPPER = 1'b1,
  localparam int OFF_W    = ADDR_W - 1,
  localparam int HALF     = 1 << OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [1:0]        req_mode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        rd_target,
  output logic [OFF_W-1:0]  rd_offset,
  output logic [2:0]        rd_bitpos,
  output logic              sfr_en,
  output logic              sfr_we,
  output logic [ADDR_W-1:0] sfr_addr,
  output logic [DATA_W-1:0] sfr_wdata,
  input  logic [DATA_W-1:0] sfr_rdata
);
  idm_tgt_e         tgt;
  logic [OFF_W-1:0] off;
  logic [2:0]       bitpos;

  idm_addr_map #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .BANK_W(BANK_W),
    .BIT_BASE(BIT_BASE), .HAS_UPPER(HAS_UPPER)
  ) u_map (
    .mode(req_mode), .addr(req_addr), .rsel(req_reg), .bank(bank_sel),
    .tgt(tgt), .off(off), .bitpos(bitpos)
  );

  logic              low_en;
  logic [DATA_W-1:0] low_q;
  logic [DATA_W-1:0] up_q;
  logic [DATA_W-1:0] sfr_q;

  assign low_en = req_valid && (tgt == TGT_LOW);

  idm_spram #(.DEPTH(HALF), .DW(DATA_W)) u_low (
    .clk(clk), .en(low_en), .we(req_we), .addr(off),
    .wdata(req_wdata), .rdata(low_q)
  );

  generate
    if (HAS_UPPER) begin : g_upper
      logic up_en;
      assign up_en = req_valid && (tgt == TGT_UP);
      idm_spram #(.DEPTH(HALF), .DW(DATA_W)) u_up (
        .clk(clk), .en(up_en), .we(req_we), .addr(off),
        .wdata(req_wdata), .rdata(up_q)
      );
    end else begin : g_no_upper
      assign up_q = '0;
    end
  endgenerate

  assign sfr_en    = req_valid && (tgt == TGT_SFR);
  assign sfr_we    = sfr_en && req_we;
  assign sfr_addr  = {1'b1, off};
  assign sfr_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (sfr_en && !req_we) sfr_q <= sfr_rdata;
  end

  idm_tgt_e tgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      tgt_q     <= TGT_LOW;
      rd_offset <= '0;
      rd_bitpos <= '0;
    end else begin
      rd_valid <= req_valid && !req_we;
      if (req_valid && !req_we) begin
        tgt_q     <= tgt;
        rd_offset <= off;
        rd_bitpos <= bitpos;
      end
    end
  end

  assign rd_target = tgt_q;

  always_comb begin
    unique case (tgt_q)
      TGT_LOW: rd_data = low_q;
      TGT_UP:  rd_data = up_q;
      TGT_SFR: rd_data = sfr_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/idm_decoder_chk.sv
module idm_decoder_chk #(
  parameter bit HAS_UPPER = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_we,
  input logic [1:0] req_mode,
  input logic [7:0] req_addr,
  input logic [2:0] req_reg,
  input logic [1:0] bank_sel,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic [1:0] rd_target,
  input logic [6:0] rd_offset,
  input logic       sfr_en,
  input logic       sfr_we
);
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> !rd_valid);

  a_r7_result_next_cycle: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_we) |=> rd_valid);

  a_r7_no_result_otherwise: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_we) |=> !rd_valid);

  a_r8_sfr_write_strobe: assert property (@(posedge clk) disable iff (rst)
    sfr_we |-> (sfr_en && req_we && req_valid));

  a_r2_low_half: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_we && req_mode[1] == 1'b0 && !req_addr[7])
    |=> (rd_target == 2'd0 && rd_offset == $past(req_addr[6:0])));

  a_r4_upper_half: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_we && req_mode == 2'd1 && req_addr[7])
    |=> (rd_target == (HAS_UPPER ? 2'd1 : 2'd3)));

  a_r5_bank_offset: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_we && req_mode == 2'd2)
    |=> (rd_offset == {2'b00, $past(bank_sel), $past(req_reg)}));

  a_r9_absent_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_target == 2'd3) |-> (rd_data == 8'h00));
endmodule

bind idm_decoder idm_decoder_chk #(.HAS_UPPER(HAS_UPPER)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
  .req_mode(req_mode), .req_addr(req_addr), .req_reg(req_reg),
  .bank_sel(bank_sel), .rd_valid(rd_valid), .rd_data(rd_data),
  .rd_target(rd_target), .rd_offset(rd_offset),
  .sfr_en(sfr_en), .sfr_we(sfr_we)
);

// File: tb/tb_idm_decoder.sv
`timescale 1ns/1ps
module tb_idm_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_we = 1'b0;
  logic [1:0] req_mode = 2'd0;
  logic [7:0] req_addr = 8'h00;
  logic [2:0] req_reg = 3'd0;
  logic [1:0] bank_sel = 2'd0;
  logic [7:0] req_wdata = 8'h00;

  logic       rd_valid, sfr_en, sfr_we;
  logic [7:0] rd_data, sfr_addr, sfr_wdata, sfr_rdata;
  logic [1:0] rd_target;
  logic [6:0] rd_offset;
  logic [2:0] rd_bitpos;

  logic       n_valid, n_sfr_en, n_sfr_we;
  logic [7:0] n_data, n_sfr_addr, n_sfr_wdata, n_sfr_rdata;
  logic [1:0] n_target;
  logic [6:0] n_offset;
  logic [2:0] n_bitpos;

  always #4 clk = ~clk;

  assign sfr_rdata   = sfr_addr ^ 8'h5A;
  assign n_sfr_rdata = n_sfr_addr ^ 8'h5A;

  idm_decoder dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_mode(req_mode), .req_addr(req_addr), .req_reg(req_reg),
    .bank_sel(bank_sel), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_target(rd_target),
    .rd_offset(rd_offset), .rd_bitpos(rd_bitpos),
    .sfr_en(sfr_en), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  idm_decoder #(.HAS_UPPER(1'b0)) dut_nu (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_mode(req_mode), .req_addr(req_addr), .req_reg(req_reg),
    .bank_sel(bank_sel), .req_wdata(req_wdata),
    .rd_valid(n_valid), .rd_data(n_data), .rd_target(n_target),
    .rd_offset(n_offset), .rd_bitpos(n_bitpos),
    .sfr_en(n_sfr_en), .sfr_we(n_sfr_we), .sfr_addr(n_sfr_addr),
    .sfr_wdata(n_sfr_wdata), .sfr_rdata(n_sfr_rdata)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] lmem [128];
  logic [7:0] umem [128];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive on a falling edge, let one rising edge capture, return at the next falling edge.
  task automatic issue(input bit we, input logic [1:0] md, input logic [7:0] a,
                       input logic [2:0] r, input logic [1:0] b, input logic [7:0] wd);
    req_valid = 1'b1; req_we = we; req_mode = md; req_addr = a;
    req_reg = r; bank_sel = b; req_wdata = wd;
    #1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic expect_rd(input string req, input logic [1:0] tg, input logic [6:0] of,
                           input logic [7:0] d);
    chk(rd_valid == 1'b1, req, rd_valid, 1);
    chk(rd_target == tg, req, rd_target, tg);
    chk(rd_offset == of, req, rd_offset, of);
    chk(rd_data == d, req, rd_data, d);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    chk(sfr_en == 1'b0 && sfr_we == 1'b0, "R1 sfr idle", {sfr_en, sfr_we}, 0);

    // Fill lower RAM through direct writes; R7: no result for a write
    for (int i = 0; i < 128; i++) begin
      lmem[i] = 8'(i * 7 + 3);
      issue(1'b1, 2'd0, 8'(i), 3'd0, 2'd0, lmem[i]);
      chk(rd_valid == 1'b0, "R7 write gives no result", rd_valid, 0);
    end
    // Fill upper RAM through indirect writes; R8: SFR port untouched
    for (int i = 0; i < 128; i++) begin
      umem[i] = 8'(i * 13) ^ 8'hC3;
      req_valid = 1'b1; req_we = 1'b1; req_mode = 2'd1; req_addr = 8'(i + 128);
      req_wdata = umem[i];
      #1;
      chk(sfr_we == 1'b0 && sfr_en == 1'b0, "R8 upper write off sfr port", sfr_we, 0);
      chk(n_sfr_we == 1'b0, "R9 absent upper write off sfr port", n_sfr_we, 0);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_we = 1'b0;
    end

    // R2: direct and indirect reads of the lower half
    for (int i = 0; i < 128; i++) begin
      issue(1'b0, 2'd0, 8'(i), 3'd0, 2'd0, 8'h00);
      expect_rd("R2 direct low", 2'd0, 7'(i), lmem[i]);
      issue(1'b0, 2'd1, 8'(i), 3'd0, 2'd0, 8'h00);
      expect_rd("R2 indirect low", 2'd0, 7'(i), lmem[i]);
      chk(n_data == lmem[i], "R2 low without upper", n_data, lmem[i]);
    end

    // R4 and R9: indirect reads of the upper half
    for (int i = 128; i < 256; i++) begin
      issue(1'b0, 2'd1, 8'(i), 3'd0, 2'd0, 8'h00);
      expect_rd("R4 indirect upper", 2'd1, 7'(i - 128), umem[i - 128]);
      chk(n_target == 2'd3, "R9 target", n_target, 3);
      chk(n_data == 8'h00, "R9 reads zero", n_data, 0);
    end

    // R3: direct reads of SFR space
    for (int i = 128; i < 256; i++) begin
      req_valid = 1'b1; req_mode = 2'd0; req_addr = 8'(i);
      #1;
      chk(sfr_en == 1'b1 && sfr_addr == 8'(i), "R3 sfr strobe", sfr_addr, i);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      expect_rd("R3 direct sfr", 2'd2, 7'(i - 128), 8'(i) ^ 8'h5A);
    end

    // R5: register operands across all banks, address input is junk
    for (int b = 0; b < 4; b++) begin
      for (int n = 0; n < 8; n++) begin
        issue(1'b0, 2'd2, 8'(8'hA5 + b * 8 + n), 3'(n), 2'(b), 8'h00);
        expect_rd("R5 register bank", 2'd0, 7'(b * 8 + n), lmem[b * 8 + n]);
      end
    end

    // R6: bit addresses
    for (int a = 0; a < 256; a++) begin
      issue(1'b0, 2'd3, 8'(a), 3'd0, 2'd0, 8'h00);
      chk(rd_bitpos == 3'(a), "R6 bit position", rd_bitpos, a & 7);
      if (a < 128)
        expect_rd("R6 bit low", 2'd0, 7'(32 + (a >> 3)), lmem[32 + (a >> 3)]);
      else
        expect_rd("R6 bit sfr", 2'd2, 7'((a & 8'hF8) - 128), 8'(a & 8'hF8) ^ 8'h5A);
    end

    // R8: SFR writes do not reach the upper RAM
    for (int i = 128; i < 256; i += 9) begin
      req_valid = 1'b1; req_we = 1'b1; req_mode = 2'd0; req_addr = 8'(i);
      req_wdata = 8'h99;
      #1;
      chk(sfr_we == 1'b1 && sfr_wdata == 8'h99, "R8 sfr write strobe", sfr_we, 1);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_we = 1'b0;
      issue(1'b0, 2'd1, 8'(i), 3'd0, 2'd0, 8'h00);
      expect_rd("R8 upper kept after sfr write", 2'd1, 7'(i - 128), umem[i - 128]);
    end

    // R5/R8: register write lands in bank 2 R5 only
    issue(1'b1, 2'd2, 8'hEE, 3'd5, 2'd2, 8'h6D);
    lmem[21] = 8'h6D;
    issue(1'b0, 2'd0, 8'h15, 3'd0, 2'd0, 8'h00);
    expect_rd("R5 register write lands", 2'd0, 7'h15, 8'h6D);
    issue(1'b0, 2'd1, 8'h95, 3'd0, 2'd0, 8'h00);
    expect_rd("R8 upper untouched by register write", 2'd1, 7'h15, umem[21]);

    // R9: a write to the absent upper half is dropped
    issue(1'b1, 2'd1, 8'h80, 3'd0, 2'd0, 8'h77);
    issue(1'b0, 2'd1, 8'h80, 3'd0, 2'd0, 8'h00);
    chk(n_data == 8'h00, "R9 write discarded", n_data, 0);
    chk(rd_data == 8'h77, "R4 upper write kept", rd_data, 8'h77);

    // R7: idle cycle after a read drops rd_valid
    @(negedge clk);
    chk(rd_valid == 1'b0, "R7 idle no result", rd_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule